// File: doc/BRIEF.md
# NAND Flash Bus Cycle Bridge

This block sits between a simple processor request/acknowledge bus and a parallel NAND flash bus. A processor access to the NAND window turns into one or more NAND cycles of the configured bus width. Bits of the access address control the latch strobes. Address bit 4 requests a command-latch cycle. Address bit 3 requests an address-latch cycle. One configurable higher bit steers the cycle to the second die of a multichip package. Because the two lowest address bits play no part, software can move a whole 32-bit word with one access. The bridge then runs the required number of byte or halfword cycles, with the first cycle on the lowest byte lane. It holds the processor until the last cycle has finished.

Each of the core chip selects has two NAND chip enables, one for the primary die and one for the secondary die. A window access goes out only if the chip select has been put in NAND mode through the control register. Otherwise the access is acknowledged at once and nothing happens on the flash bus. A status register reports the shared, wire-ANDed ready/busy line. Strobe timing is fixed:
- one setup cycle for chip enable and the latch strobes;
- then, for each NAND cycle, two cycles with the strobe low and two with it high.

The sequencer has six states, all reached from IDLE:
- IDLE → ACK when a register access, or a window access to a chip select that is not enabled, is accepted.
- IDLE → SETUP when an enabled window access is accepted.
- SETUP → LOW after the setup time.
- LOW → HIGH after the low time.
- HIGH → LOW when more beats remain.
- HIGH → DONE after the last beat.
- ACK → IDLE and DONE → IDLE unconditionally.

Top module: `nand_bridge`

## Requirements
- R1: A window access with address bit 4 set drives the command-latch output high for the whole access, whatever address bit 3 is, and the address-latch output stays low.
- R2: A window access with address bit 3 set and bit 4 clear drives the address-latch output high for the whole access, and the command-latch output stays low. With both bits clear, both latch outputs stay low.
- R3: A window access runs a number of NAND cycles equal to its byte count divided by the bus width in bytes, and at least one. Size code 0 is a byte, 1 a halfword, and 2 or 3 a word. Address bits 1:0 are ignored. For a write, beat k drives write-data bits [k*W +: W], where W is the bus width.
- R4: Read data is assembled little-endian. Beat k lands in result bits [k*W +: W], and result bits above the transferred bytes read 0.
- R5: Address bit SEC_BIT (default 12) selects the chip enable: clear gives index 2*cs, set gives index 2*cs+1. At most one chip enable is ever low.
- R6: The control register is at register offset 0, selected when address bit 2 is clear. Its bits [NUM_CS-1:0] enable NAND mode for each chip select, and it resets to 0. A window access to a chip select that is not enabled toggles no strobe, drives no chip enable and returns 0.
- R7: The status register is at register offset 4, selected when address bit 2 is set. Its bit 0 reads 1 when the ready/busy input is high and 0 when it is low. Writes to it have no effect.
- R8: Chip enable and the latch outputs are valid for one cycle before the first strobe. Each strobe is low for 2 cycles and high for 2 cycles. Chip enable and the latch outputs stay stable for the whole access. Write data is stable while write-enable is low.
- R9: The ready output is a one-cycle pulse. It comes 2 + 4*beats cycles after an enabled window access is accepted, and 1 cycle after a register access or a disabled window access is accepted.
- R10: The bus width parameter BUS_W may be 8 or 16. On a 16-bit bus, a word access takes two halfword cycles and a byte access takes one cycle on the low lane.
- R11: After reset, all chip enables, write-enable and read-enable are high, both latch outputs are low, the data bus is not driven, and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request; held with its fields until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 1 | 1 = register space, 0 = NAND window |
| cpu_cs | input | CS_W | Core chip select of a window access |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_addr | input | ADDR_W | Byte address within window or register space |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| nand_ce_n | output | 2*NUM_CS | Chip enables, index 2*cs + secondary |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | BUS_W | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | BUS_W | Data bus in |
| nand_rb | input | 1 | Wire-ANDed ready/busy, high = ready |

## Verification
On every cycle, the embedded assertions check that at most one chip enable is low and that the two latch outputs are never high together. They also check that a strobe only moves while a chip enable is active and is preceded by a setup cycle, that every low phase lasts exactly the fixed width, that control lines and write data hold steady during an access, and that ready is a single pulse. Only the directed scenarios can show which latch strobe a given address produces, the beat count and lane order, the assembled read word, the chip-enable selection, the register contents, and the exact acknowledge latency. Each scenario checks these against values worked out from the requirements.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } nb_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam int CLE_BIT = 4;
    localparam int ALE_BIT = 3;
    localparam int REG_SEL_BIT = 2;

endpackage

// File: rtl/nand_bridge_decode.sv
module nand_bridge_decode
    import nand_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BUS_W   = 8,
    parameter int SEC_BIT = 12,
    localparam int MAX_BEATS = 32 / BUS_W,
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int LANE_SH   = $clog2(BUS_W / 8)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              cle,
    output logic              ale,
    output logic              sec,
    output logic [BEAT_W-1:0] last_beat
);
    logic [1:0] bytes_m1;
    logic       addr_unused;

    assign addr_unused = ^addr;

    always_comb begin
        cle = addr[CLE_BIT];
        ale = addr[ALE_BIT] & ~addr[CLE_BIT];
        sec = addr[SEC_BIT];
        unique case (size)
            SZ_BYTE: bytes_m1 = 2'd0;
            SZ_HALF: bytes_m1 = 2'd1;
            default: bytes_m1 = 2'd3;
        endcase
        last_beat = BEAT_W'(bytes_m1 >> LANE_SH);
    end

endmodule

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_status,
    input  logic [NUM_CS-1:0] wdata,
    input  logic              rb,
    output logic [NUM_CS-1:0] mode_en,
    output logic [31:0]       rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en <= '0;
        end else if (wr_en && !sel_status) begin
            mode_en <= wdata;
        end
    end

    always_comb begin
        if (sel_status) begin
            rdata = {31'd0, rb};
        end else begin
            rdata = {{(32 - NUM_CS){1'b0}}, mode_en};
        end
    end

endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
    import nand_bridge_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int NUM_CS = 4,
    parameter int T_SU   = 1,
    parameter int T_LO   = 2,
    parameter int T_HI   = 2,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int MAX_BEATS = 32 / BUS_W,
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int T_MAX     = (T_SU > T_LO) ? ((T_SU > T_HI) ? T_SU : T_HI)
                                             : ((T_LO > T_HI) ? T_LO : T_HI),
    localparam int CNT_W     = $clog2(T_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic                cpu_reg,
    input  logic [CS_W-1:0]     cpu_cs,
    input  logic [31:0]         cpu_wdata,
    input  logic [NUM_CS-1:0]   mode_en,
    input  logic [31:0]         reg_rdata,
    input  logic                dec_cle,
    input  logic                dec_ale,
    input  logic                dec_sec,
    input  logic [BEAT_W-1:0]   dec_last,
    output logic                reg_write,
    output logic                cpu_ready,
    output logic [31:0]         cpu_rdata,
    output logic [2*NUM_CS-1:0] nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [BUS_W-1:0]    nand_dq_o,
    output logic                nand_dq_oe,
    input  logic [BUS_W-1:0]    nand_dq_i
);
    nb_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BEAT_W-1:0] beat_q, last_q;
    logic [CS_W-1:0]   cs_q;
    logic              sec_q, cle_q, ale_q, write_q;
    logic [31:0]       wdata_q;
    logic [BUS_W-1:0]  wr_lane [MAX_BEATS];
    logic [BUS_W-1:0]  rd_lane_q [MAX_BEATS];
    logic              accept, win_go, busy;
    logic              lo_end, hi_end, su_end;
    logic [31:0]       acc_rdata;

    assign accept    = (state_q == ST_IDLE) && cpu_valid;
    assign win_go    = accept && !cpu_reg && mode_en[cpu_cs];
    assign reg_write = accept && cpu_reg && cpu_write;
    assign acc_rdata = (cpu_reg && !cpu_write) ? reg_rdata : 32'd0;
    assign su_end    = (cnt_q == CNT_W'(T_SU - 1));
    assign lo_end    = (cnt_q == CNT_W'(T_LO - 1));
    assign hi_end    = (cnt_q == CNT_W'(T_HI - 1));

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_lane
        assign wr_lane[g] = wdata_q[g*BUS_W +: BUS_W];
        assign cpu_rdata[g*BUS_W +: BUS_W] = rd_lane_q[g];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = win_go ? ST_SETUP : ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            ST_SETUP: if (su_end) state_d = ST_LOW;
            ST_LOW:   if (lo_end) state_d = ST_HIGH;
            ST_HIGH:  if (hi_end) state_d = (beat_q == last_q) ? ST_DONE : ST_LOW;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // Access context and data lanes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            last_q  <= '0;
            cs_q    <= '0;
            sec_q   <= 1'b0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            for (int i = 0; i < MAX_BEATS; i++) rd_lane_q[i] <= '0;
        end else begin
            if (accept) begin
                beat_q  <= '0;
                last_q  <= dec_last;
                cs_q    <= cpu_cs;
                sec_q   <= dec_sec;
                cle_q   <= dec_cle;
                ale_q   <= dec_ale;
                write_q <= cpu_write;
                wdata_q <= cpu_wdata;
                for (int i = 0; i < MAX_BEATS; i++) begin
                    rd_lane_q[i] <= acc_rdata[i*BUS_W +: BUS_W];
                end
            end
            if (state_q == ST_LOW && lo_end && !write_q) begin
                rd_lane_q[beat_q] <= nand_dq_i;
            end
            if (state_q == ST_HIGH && hi_end && beat_q != last_q) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        busy       = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
        nand_ce_n  = '1;
        if (busy) nand_ce_n[{cs_q, sec_q}] = 1'b0;
        nand_cle   = busy && cle_q;
        nand_ale   = busy && ale_q;
        nand_we_n  = !((state_q == ST_LOW) && write_q);
        nand_re_n  = !((state_q == ST_LOW) && !write_q);
        nand_dq_oe = busy && write_q;
        nand_dq_o  = wr_lane[beat_q];
        cpu_ready  = (state_q == ST_ACK) || (state_q == ST_DONE);
    end

    // Checks
    logic       strobe_low;
    logic [7:0] lo_run;
    assign strobe_low = !nand_we_n || !nand_re_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_run <= '0;
        else        lo_run <= strobe_low ? lo_run + 1'b1 : 8'd0;
    end

    assert_ce_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_strobe_needs_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> (nand_ce_n != '1));

    assert_setup_before_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_low && !$past(strobe_low)) |-> ($past(nand_ce_n) != '1));

    assert_low_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_low) && !strobe_low) |-> (lo_run == 8'(T_LO)));

    assert_ctl_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((nand_ce_n != '1) && ($past(nand_ce_n) != '1))
            |-> ($stable(nand_ce_n) && $stable(nand_cle) && $stable(nand_ale)));

    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nand_bridge_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int NUM_CS  = 4,
    parameter int ADDR_W  = 16,
    parameter int SEC_BIT = 12,
    parameter int T_SU    = 1,
    parameter int T_LO    = 2,
    parameter int T_HI    = 2,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int MAX_BEATS = 32 / BUS_W,
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    input  logic                cpu_write,
    input  logic                cpu_reg,
    input  logic [CS_W-1:0]     cpu_cs,
    input  logic [1:0]          cpu_size,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [31:0]         cpu_wdata,
    output logic                cpu_ready,
    output logic [31:0]         cpu_rdata,
    output logic [2*NUM_CS-1:0] nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [BUS_W-1:0]    nand_dq_o,
    output logic                nand_dq_oe,
    input  logic [BUS_W-1:0]    nand_dq_i,
    input  logic                nand_rb
);
    if (!(BUS_W == 8 || BUS_W == 16)) begin : g_width_chk
        $error("nand_bridge: BUS_W must be 8 or 16");
    end

    logic              dec_cle, dec_ale, dec_sec;
    logic [BEAT_W-1:0] dec_last;
    logic [NUM_CS-1:0] mode_en;
    logic [31:0]       reg_rdata;
    logic              reg_write;

    nand_bridge_decode #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .SEC_BIT(SEC_BIT)
    ) u_decode (
        .addr     (cpu_addr),
        .size     (cpu_size),
        .cle      (dec_cle),
        .ale      (dec_ale),
        .sec      (dec_sec),
        .last_beat(dec_last)
    );

    nand_bridge_regs #(
        .NUM_CS(NUM_CS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_write),
        .sel_status(cpu_addr[REG_SEL_BIT]),
        .wdata     (cpu_wdata[NUM_CS-1:0]),
        .rb        (nand_rb),
        .mode_en   (mode_en),
        .rdata     (reg_rdata)
    );

    nand_bridge_seq #(
        .BUS_W (BUS_W),
        .NUM_CS(NUM_CS),
        .T_SU  (T_SU),
        .T_LO  (T_LO),
        .T_HI  (T_HI)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_reg   (cpu_reg),
        .cpu_cs    (cpu_cs),
        .cpu_wdata (cpu_wdata),
        .mode_en   (mode_en),
        .reg_rdata (reg_rdata),
        .dec_cle   (dec_cle),
        .dec_ale   (dec_ale),
        .dec_sec   (dec_sec),
        .dec_last  (dec_last),
        .reg_write (reg_write),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .nand_ce_n (nand_ce_n),
        .nand_cle  (nand_cle),
        .nand_ale  (nand_ale),
        .nand_we_n (nand_we_n),
        .nand_re_n (nand_re_n),
        .nand_dq_o (nand_dq_o),
        .nand_dq_oe(nand_dq_oe),
        .nand_dq_i (nand_dq_i)
    );

endmodule

// File: tb/nand_bridge_tb.sv
`timescale 1ns/1ps
module nand_bridge_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rb = 1'b1;
    int   n_tests = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    // 8-bit instance
    logic        v8 = 0, w8 = 0, g8 = 0;
    logic [1:0]  cs8 = 0, sz8 = 0;
    logic [15:0] a8 = 0;
    logic [31:0] wd8 = 0, rd8;
    logic        rdy8, cle8, ale8, we8, re8, oe8;
    logic [7:0]  ce8, dqo8, dqi8;

    // 16-bit instance
    logic        v16 = 0, w16 = 0, g16 = 0;
    logic [1:0]  cs16 = 0, sz16 = 0;
    logic [15:0] a16 = 0;
    logic [31:0] wd16 = 0, rd16;
    logic        rdy16, cle16, ale16, we16, re16, oe16;
    logic [7:0]  ce16;
    logic [15:0] dqo16, dqi16;

    nand_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(v8), .cpu_write(w8), .cpu_reg(g8),
        .cpu_cs(cs8), .cpu_size(sz8), .cpu_addr(a8), .cpu_wdata(wd8),
        .cpu_ready(rdy8), .cpu_rdata(rd8), .nand_ce_n(ce8), .nand_cle(cle8),
        .nand_ale(ale8), .nand_we_n(we8), .nand_re_n(re8), .nand_dq_o(dqo8),
        .nand_dq_oe(oe8), .nand_dq_i(dqi8), .nand_rb(rb)
    );

    nand_bridge #(.BUS_W(16)) u_dut_w16 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(v16), .cpu_write(w16), .cpu_reg(g16),
        .cpu_cs(cs16), .cpu_size(sz16), .cpu_addr(a16), .cpu_wdata(wd16),
        .cpu_ready(rdy16), .cpu_rdata(rd16), .nand_ce_n(ce16), .nand_cle(cle16),
        .nand_ale(ale16), .nand_we_n(we16), .nand_re_n(re16), .nand_dq_o(dqo16),
        .nand_dq_oe(oe16), .nand_dq_i(dqi16), .nand_rb(rb)
    );

    // NAND device models: log write cycles, serve incrementing read data
    int          wn8 = 0, rn8 = 0, ri8 = 0, wn16 = 0, rn16 = 0, ri16 = 0;
    logic [7:0]  wl_d8 [16];
    logic [7:0]  wl_e8 [16];
    logic        wl_c8 [16];
    logic        wl_a8 [16];
    logic [15:0] wl_d16 [16];

    assign dqi8  = 8'hA0 + 8'(ri8);
    assign dqi16 = 16'hB000 + 16'(ri16);

    always @(posedge we8) begin
        if (wn8 < 16) begin
            wl_d8[wn8] = dqo8; wl_e8[wn8] = ce8; wl_c8[wn8] = cle8; wl_a8[wn8] = ale8;
        end
        wn8 = wn8 + 1;
    end
    always @(posedge re8) begin rn8 = rn8 + 1; ri8 = ri8 + 1; end
    always @(posedge we16) begin
        if (wn16 < 16) wl_d16[wn16] = dqo16;
        wn16 = wn16 + 1;
    end
    always @(posedge re16) begin rn16 = rn16 + 1; ri16 = ri16 + 1; end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clr_logs();
        wn8 = 0; rn8 = 0; ri8 = 0; wn16 = 0; rn16 = 0; ri16 = 0;
    endtask

    task automatic acc8(input logic wr, input logic rg, input logic [1:0] cs,
                        input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        v8 = 1; w8 = wr; g8 = rg; cs8 = cs; sz8 = sz; a8 = addr; wd8 = wd;
        lat = 0; rd = '0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lat++;
            if (rdy8) begin rd = rd8; break; end
        end
        v8 = 0;
    endtask

    task automatic acc16(input logic wr, input logic rg, input logic [1:0] sz,
                         input logic [15:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
        @(negedge clk);
        v16 = 1; w16 = wr; g16 = rg; cs16 = 0; sz16 = sz; a16 = addr; wd16 = wd;
        lat = 0; rd = '0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lat++;
            if (rdy16) begin rd = rd16; break; end
        end
        v16 = 0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int lat;
        @(negedge clk);
        chk("R11 ce_n", 32'(ce8), 32'hFF);
        chk("R11 strobes/latches/oe/ready", {26'd0, we8, re8, cle8, ale8, oe8, rdy8}, 32'h30);
        acc8(0, 1, 0, 2, 16'h0, 0, rd, lat);
        chk("R6 control reset value", rd, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] rd; int lat;
        acc8(1, 1, 0, 2, 16'h0, 32'hFFFF_FFF3, rd, lat);
        chk("R9 register latency", 32'(lat), 32'd1);
        acc8(0, 1, 0, 2, 16'h0, 0, rd, lat);
        chk("R6 control readback", rd, 32'h3);
        acc8(1, 1, 0, 2, 16'h4, 32'h0, rd, lat);
        acc8(0, 1, 0, 2, 16'h0, 0, rd, lat);
        chk("R7 status write ignored", rd, 32'h3);
        rb = 1;
        acc8(0, 1, 0, 2, 16'h4, 0, rd, lat);
        chk("R7 status ready", rd, 32'h1);
        rb = 0;
        acc8(0, 1, 0, 2, 16'h4, 0, rd, lat);
        chk("R7 status busy", rd, 32'h0);
        rb = 1;
    endtask

    task automatic t_cmd();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(1, 0, 0, 0, 16'h0010, 32'h70, rd, lat);
        chk("R1 command cycle count", 32'(wn8), 32'd1);
        chk("R1 command latch", {30'd0, wl_c8[0], wl_a8[0]}, 32'h2);
        chk("R5 primary ce cs0", 32'(wl_e8[0]), 32'hFE);
        chk("R3 command data", 32'(wl_d8[0]), 32'h70);
        chk("R9 byte latency", 32'(lat), 32'd6);
        clr_logs();
        acc8(1, 0, 0, 0, 16'h0018, 32'h55, rd, lat);
        chk("R1 bit4 wins over bit3", {30'd0, wl_c8[0], wl_a8[0]}, 32'h2);
    endtask

    task automatic t_addr_word();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(1, 0, 0, 2, 16'h000B, 32'h4433_2211, rd, lat);
        chk("R3 word beats on 8-bit bus", 32'(wn8), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 lane order", 32'(wl_d8[k]), 32'h11 * (k + 1));
            chk("R2 address latch each beat", {30'd0, wl_c8[k], wl_a8[k]}, 32'h1);
        end
        chk("R9 word latency", 32'(lat), 32'd18);
    endtask

    task automatic t_data_half();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(1, 0, 0, 1, 16'h0000, 32'h0000_BEEF, rd, lat);
        chk("R3 half beats", 32'(wn8), 32'd2);
        chk("R3 half lane0", 32'(wl_d8[0]), 32'hEF);
        chk("R3 half lane1", 32'(wl_d8[1]), 32'hBE);
        chk("R2 plain data no latch", {30'd0, wl_c8[1], wl_a8[1]}, 32'h0);
        chk("R9 half latency", 32'(lat), 32'd10);
    endtask

    task automatic t_secondary();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(1, 0, 1, 0, 16'h1000, 32'h90, rd, lat);
        acc8(1, 0, 1, 0, 16'h0000, 32'h91, rd, lat);
        chk("R5 secondary ce cs1", 32'(wl_e8[0]), 32'hF7);
        chk("R5 primary ce cs1", 32'(wl_e8[1]), 32'hFB);
    endtask

    task automatic t_reads();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(0, 0, 0, 2, 16'h0000, 0, rd, lat);
        chk("R4 word read assembly", rd, 32'hA3A2_A1A0);
        chk("R3 read beats", 32'(rn8), 32'd4);
        chk("R3 read no write strobe", 32'(wn8), 32'd0);
        chk("R9 read latency", 32'(lat), 32'd18);
        clr_logs();
        ri8 = 5;
        acc8(0, 0, 0, 0, 16'h0000, 0, rd, lat);
        chk("R4 byte read upper zero", rd, 32'h0000_00A5);
    endtask

    task automatic t_disabled();
        logic [31:0] rd; int lat;
        clr_logs();
        acc8(1, 0, 2, 2, 16'h0010, 32'h1234_5678, rd, lat);
        chk("R6 disabled cs no strobe", 32'(wn8), 32'd0);
        chk("R9 disabled latency", 32'(lat), 32'd1);
        acc8(0, 0, 3, 2, 16'h0000, 0, rd, lat);
        chk("R6 disabled read zero", rd, 32'h0);
        chk("R6 disabled read no strobe", 32'(rn8), 32'd0);
        chk("R6 ce idle after disabled", 32'(ce8), 32'hFF);
    endtask

    task automatic t_wide_bus();
        logic [31:0] rd; int lat;
        acc16(1, 1, 2, 16'h0, 32'h1, rd, lat);
        clr_logs();
        acc16(1, 0, 2, 16'h0000, 32'h4433_2211, rd, lat);
        chk("R10 word beats on 16-bit bus", 32'(wn16), 32'd2);
        chk("R10 beat0", 32'(wl_d16[0]), 32'h2211);
        chk("R10 beat1", 32'(wl_d16[1]), 32'h4433);
        chk("R10 latency", 32'(lat), 32'd10);
        clr_logs();
        acc16(0, 0, 2, 16'h0000, 0, rd, lat);
        chk("R10 R4 word read assembly", rd, 32'hB001_B000);
        clr_logs();
        acc16(1, 0, 0, 16'h0000, 32'h7A, rd, lat);
        chk("R10 byte one beat", 32'(wn16), 32'd1);
        chk("R10 byte low lane", 32'(wl_d16[0]), 32'h007A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        clr_logs();
        t_reset();
        t_regs();
        t_cmd();
        t_addr_word();
        t_data_half();
        t_secondary();
        t_reads();
        t_disabled();
        t_wide_bus();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule